// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a physical address. It reads one or two descriptor words from a page table held in memory. A requester hands it one virtual address at a time. The walker then fetches the first-level descriptor through a single-outstanding memory read port. If that descriptor points to a coarse second-level table, it fetches a second descriptor from that table. It finally returns a one-cycle response that carries the physical address, a page size code and a fault flag.

Software sets up the walker through a small word-addressed register port. The registers hold:
- a run bit;
- the base address of the first-level table;
- a five-bit interrupt status field, in which software clears a bit by writing 1 to it;
- a matching interrupt enable field;
- a read-only copy of the last virtual address that failed to translate.

A translation fault sets status bit 1. The interrupt line rises whenever a set status bit also has its enable bit set.

Top module: `pw_walker`

## Requirements
- R1: `reqReady` is high only when the run bit (config word 0, bit 0) is 1 and no walk is in progress. A request presented while the walker is stopped or busy is neither accepted nor read from memory. A walk that has already started finishes even if the run bit is cleared.
- R2: The first descriptor read goes to the table base (config word 1) plus the virtual address bits [31:20] multiplied by 4. The sum wraps at 32 bits.
- R3: A first-level descriptor with bits [1:0] = 10 and bit 18 clear gives a 1 MB section. The response has size code 3 and physical address {desc[31:20], va[19:0]}.
- R4: A first-level descriptor with bits [1:0] = 10 and bit 18 set gives a 16 MB supersection. The response has size code 4 and physical address {desc[31:24], va[23:0]}.
- R5: A first-level descriptor with bits [1:0] = 01 causes a second read at address {desc[31:10], va[19:12], 2'b00}.
- R6: A second-level descriptor with bit 1 set gives a 4 KB page, whatever the value of bit 0. The response has size code 1 and physical address {desc[31:12], va[11:0]}.
- R7: A second-level descriptor with bits [1:0] = 01 gives a 64 KB page. The response has size code 2 and physical address {desc[31:16], va[15:0]}.
- R8: Any of the following gives a response with `rspFault` = 1, size code 0 and physical address 0:
  - a first-level descriptor whose bits [1:0] are 00 or 11 (no second read is made in this case);
  - a second-level descriptor whose bits [1:0] are 00.
- R9: A fault response sets bit 1 of the status field (config word 2) in the same cycle as the response, and copies the faulting virtual address into config word 4. Writing 1 to a status bit clears it; writing 0 to it leaves it unchanged.
- R10: `irqOut` equals the OR over the five bits of status AND enable (config word 3).
- R11: At most one memory read is outstanding at a time. Once `memReqValid` is raised, it stays high until `memReqReady` is seen.
- R12: `rspValid` is a single-cycle pulse. It arrives in the cycle after the final descriptor arrives on `memRspValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker accepts a request |
| reqVaddr | input | 32 | Virtual address to translate |
| rspValid | output | 1 | Translation result pulse |
| rspPaddr | output | 32 | Physical address (0 on fault) |
| rspSize | output | 3 | Size code: 0 none, 1 4 KB, 2 64 KB, 3 1 MB, 4 16 MB |
| rspFault | output | 1 | Translation fault |
| memReqValid | output | 1 | Descriptor read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 32 | Descriptor word address |
| memRspValid | input | 1 | Descriptor data valid |
| memRspData | input | 32 | Descriptor word |
| cfgWe | input | 1 | Config write strobe |
| cfgAddr | input | 3 | Config word index (0 run, 1 base, 2 status, 3 enable, 4 fault address) |
| cfgWdata | input | 32 | Config write data |
| cfgRdata | output | 32 | Config read data for `cfgAddr` |
| irqOut | output | 1 | Interrupt request |

## Verification
Translations are requested for each descriptor type:
- a section and a supersection, which differ only in bit 18;
- a coarse pointer followed by a 4 KB entry, a 64 KB entry, and an entry with both type bits set, which exposes the priority between the two bits;
- first-level faults, with low bits 00 and with low bits 11;
- a second-level fault.

The memory answers with a varying acceptance stall and response latency. Every descriptor address the walker issues is compared with the address predicted for that level. The status, enable and clear operations are interleaved with faults, so the interrupt line is seen both masked and unmasked. A request held against a stopped walker shows that the hold-off works.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [2:0] {
    PG_NONE = 3'd0,
    PG_4K   = 3'd1,
    PG_64K  = 3'd2,
    PG_1M   = 3'd3,
    PG_16M  = 3'd4
  } pageSize_e;

  typedef struct packed {
    logic captureVa;
    logic useL2Addr;
    logic takeCoarse;
    logic finishL1;
    logic finishL2;
  } walkCtl_t;

  localparam logic [2:0] CFG_RUN   = 3'd0;
  localparam logic [2:0] CFG_BASE  = 3'd1;
  localparam logic [2:0] CFG_STAT  = 3'd2;
  localparam logic [2:0] CFG_IEN   = 3'd3;
  localparam logic [2:0] CFG_FADDR = 3'd4;
endpackage

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pw_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     runEn,
  input  logic     reqValid,
  input  logic     memReqReady,
  input  logic     memRspValid,
  input  logic     l1Coarse,
  output logic     reqReady,
  output logic     memReqValid,
  output walkCtl_t ctl
);
  typedef enum logic [2:0] {S_IDLE, S_L1REQ, S_L1WAIT, S_L2REQ, S_L2WAIT} state_e;
  state_e state, stateNext;

  always_comb begin
    reqReady       = runEn && (state == S_IDLE);
    memReqValid    = (state == S_L1REQ) || (state == S_L2REQ);
    ctl.captureVa  = reqValid && reqReady;
    ctl.useL2Addr  = (state == S_L2REQ);
    ctl.takeCoarse = (state == S_L1WAIT) && memRspValid && l1Coarse;
    ctl.finishL1   = (state == S_L1WAIT) && memRspValid && !l1Coarse;
    ctl.finishL2   = (state == S_L2WAIT) && memRspValid;
    stateNext = state;
    unique case (state)
      S_IDLE:   if (ctl.captureVa) stateNext = S_L1REQ;
      S_L1REQ:  if (memReqReady) stateNext = S_L1WAIT;
      S_L1WAIT: if (ctl.takeCoarse) stateNext = S_L2REQ;
                else if (ctl.finishL1) stateNext = S_IDLE;
      S_L2REQ:  if (memReqReady) stateNext = S_L2WAIT;
      S_L2WAIT: if (ctl.finishL2) stateNext = S_IDLE;
      default:  stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  // R11: a raised read request is held until accepted
  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid);

  // R1: an accepted request makes the walker busy on the next cycle
  assert_busy_blocks_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
endmodule

// File: rtl/pw_dpath.sv
module pw_dpath
  import pw_pkg::*;
#(
  parameter int AW        = 32,
  parameter int IRQ_W     = 5,
  parameter int FAULT_BIT = 1,
  parameter int CFG_AW    = 3
)(
  input  logic              clk,
  input  logic              rstN,
  input  walkCtl_t          ctl,
  input  logic [AW-1:0]     reqVaddr,
  input  logic [AW-1:0]     memRspData,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [AW-1:0]     cfgWdata,
  output logic [AW-1:0]     cfgRdata,
  output logic              runEn,
  output logic              l1Coarse,
  output logic [AW-1:0]     memReqAddr,
  output logic              rspValid,
  output logic [AW-1:0]     rspPaddr,
  output logic [2:0]        rspSize,
  output logic              rspFault,
  output logic              irqOut
);
  localparam int CB_W = AW - 10;

  logic [AW-1:0]    baseReg, vaReg, faultVa, l1Addr, decPaddr;
  logic [CB_W-1:0]  coarseBase;
  logic [IRQ_W-1:0] irqStat, irqEn, faultMask, clearMask;
  pageSize_e        decSize;
  logic             decFault, finish;
  logic             unusedBits;

  assign unusedBits = ^memRspData[9:2];
  assign l1Coarse   = (memRspData[1:0] == 2'b01);
  assign l1Addr     = baseReg + {{(AW-14){1'b0}}, vaReg[31:20], 2'b00};
  assign memReqAddr = ctl.useL2Addr ? {coarseBase, vaReg[19:12], 2'b00} : l1Addr;
  assign finish     = ctl.finishL1 || ctl.finishL2;
  assign irqOut     = |(irqStat & irqEn);

  always_comb begin
    decPaddr = '0;
    decSize  = PG_NONE;
    decFault = 1'b1;
    if (ctl.finishL2) begin
      if (memRspData[1]) begin
        decPaddr = {memRspData[31:12], vaReg[11:0]}; decSize = PG_4K; decFault = 1'b0;
      end else if (memRspData[0]) begin
        decPaddr = {memRspData[31:16], vaReg[15:0]}; decSize = PG_64K; decFault = 1'b0;
      end
    end else if (memRspData[1:0] == 2'b10) begin
      decFault = 1'b0;
      if (memRspData[18]) begin
        decPaddr = {memRspData[31:24], vaReg[23:0]}; decSize = PG_16M;
      end else begin
        decPaddr = {memRspData[31:20], vaReg[19:0]}; decSize = PG_1M;
      end
    end
  end

  always_comb begin
    faultMask = '0;
    faultMask[FAULT_BIT] = finish && decFault;
    clearMask = (cfgWe && cfgAddr == CFG_STAT) ? cfgWdata[IRQ_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn <= 1'b0; baseReg <= '0; irqStat <= '0; irqEn <= '0; faultVa <= '0;
      vaReg <= '0; coarseBase <= '0;
      rspValid <= 1'b0; rspPaddr <= '0; rspSize <= '0; rspFault <= 1'b0;
    end else begin
      rspValid <= finish;
      if (ctl.captureVa)  vaReg <= reqVaddr;
      if (ctl.takeCoarse) coarseBase <= memRspData[AW-1:10];
      if (finish) begin
        rspPaddr <= decPaddr;
        rspSize  <= decSize;
        rspFault <= decFault;
        if (decFault) faultVa <= vaReg;
      end
      irqStat <= (irqStat & ~clearMask) | faultMask;
      if (cfgWe) begin
        unique case (cfgAddr)
          CFG_RUN:  runEn   <= cfgWdata[0];
          CFG_BASE: baseReg <= cfgWdata;
          CFG_IEN:  irqEn   <= cfgWdata[IRQ_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    cfgRdata = '0;
    unique case (cfgAddr)
      CFG_RUN:   cfgRdata[0] = runEn;
      CFG_BASE:  cfgRdata = baseReg;
      CFG_STAT:  cfgRdata[IRQ_W-1:0] = irqStat;
      CFG_IEN:   cfgRdata[IRQ_W-1:0] = irqEn;
      CFG_FADDR: cfgRdata = faultVa;
      default: ;
    endcase
  end

  // R9: a fault response comes with the fault status bit set
  assert_fault_status_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> (irqStat[FAULT_BIT] && faultVa == vaReg));

  // R8: a fault carries no size and no address
  assert_fault_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> (rspSize == 3'd0 && rspPaddr == '0));

  // R3: a section keeps the low 20 virtual bits
  assert_section_offset_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspSize == 3'd3) |-> (rspPaddr[19:0] == vaReg[19:0]));

  // R12: the response is a single-cycle pulse
  assert_rsp_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
endmodule

// File: rtl/pw_walker.sv
module pw_walker
  import pw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [31:0] reqVaddr,
  output logic        rspValid,
  output logic [31:0] rspPaddr,
  output logic [2:0]  rspSize,
  output logic        rspFault,
  output logic        memReqValid,
  input  logic        memReqReady,
  output logic [31:0] memReqAddr,
  input  logic        memRspValid,
  input  logic [31:0] memRspData,
  input  logic        cfgWe,
  input  logic [2:0]  cfgAddr,
  input  logic [31:0] cfgWdata,
  output logic [31:0] cfgRdata,
  output logic        irqOut
);
  walkCtl_t ctl;
  logic     runEn, l1Coarse;

  pw_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .runEn(runEn), .reqValid(reqValid),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .l1Coarse(l1Coarse),
    .reqReady(reqReady), .memReqValid(memReqValid), .ctl(ctl)
  );

  pw_dpath #(.AW(32), .IRQ_W(5), .FAULT_BIT(1), .CFG_AW(3)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqVaddr(reqVaddr),
    .memRspData(memRspData), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .runEn(runEn),
    .l1Coarse(l1Coarse), .memReqAddr(memReqAddr), .rspValid(rspValid),
    .rspPaddr(rspPaddr), .rspSize(rspSize), .rspFault(rspFault), .irqOut(irqOut)
  );
endmodule

// File: tb/pw_walker_tb.sv
module pw_walker_tb_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqReady;
  logic [31:0] reqVaddr = '0;
  logic rspValid, rspFault, memReqValid, irqOut;
  logic [31:0] rspPaddr, memReqAddr, cfgRdata;
  logic [2:0] rspSize;
  logic memReqReady = 1'b0, memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic cfgWe = 1'b0;
  logic [2:0] cfgAddr = '0;
  logic [31:0] cfgWdata = '0;

  pw_walker dut_i (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, rspCyc = -10;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] memArr [int unsigned];
  logic [31:0] expAddr[$];
  string       expTag[$];
  logic [31:0] expPaddr[$];
  int          expSize[$];
  bit          expFault[$];
  logic [31:0] mBase = '0, lastFaultVa = '0;
  logic [4:0]  mStat = '0, mEn = '0;
  bit          mRun = 0, busy = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (memArr.exists(a)) return memArr[a];
    return 32'h0;
  endfunction

  function automatic void predict(input logic [31:0] va);
    logic [31:0] a1, d1, a2, d2, pa;
    int sz;
    a1 = mBase + {20'd0, va[31:20], 2'b00};
    expAddr.push_back(a1); expTag.push_back("R2");
    d1 = rd(a1); pa = 0; sz = 0;
    if (d1[1:0] == 2'b10) begin
      if (d1[18]) begin pa = {d1[31:24], va[23:0]}; sz = 4; end
      else        begin pa = {d1[31:20], va[19:0]}; sz = 3; end
    end else if (d1[1:0] == 2'b01) begin
      a2 = {d1[31:10], va[19:12], 2'b00};
      expAddr.push_back(a2); expTag.push_back("R5");
      d2 = rd(a2);
      if (d2[1])      begin pa = {d2[31:12], va[11:0]}; sz = 1; end
      else if (d2[0]) begin pa = {d2[31:16], va[15:0]}; sz = 2; end
    end
    expPaddr.push_back(pa); expSize.push_back(sz); expFault.push_back(sz == 0);
    if (sz == 0) lastFaultVa = va;
  endfunction

  // memory responder with varying stall and latency
  int pendCnt = 0;
  logic [31:0] pendAddr = '0;
  initial forever begin
    @(negedge clk);
    memRspValid = 1'b0;
    if (pendCnt > 0) begin
      pendCnt--;
      if (pendCnt == 0) begin
        memRspValid = 1'b1; memRspData = rd(pendAddr); rspCyc = cyc;
      end
    end
    memReqReady = (cyc % 3) != 1;
    if (memReqValid && memReqReady) begin
      chk(pendCnt == 0, "R11 single outstanding", 32'(pendCnt), 0);
      if (expAddr.size() == 0) chk(0, "R2/R5 unexpected read", memReqAddr, 0);
      else begin
        string t; logic [31:0] e;
        t = expTag.pop_front(); e = expAddr.pop_front();
        chk(memReqAddr == e, t, memReqAddr, e);
      end
      pendAddr = memReqAddr;
      pendCnt = 1 + (cyc % 2);
    end
  end

  // cycle-by-cycle comparison against the model
  initial forever begin
    @(negedge clk); #1;
    if (rstN) begin
      if (rspValid) begin
        busy = 0;
        chk(rspValid && cyc == rspCyc + 1, "R12 response timing", 32'(cyc), 32'(rspCyc + 1));
        if (expPaddr.size() == 0) chk(0, "R12 unexpected response", rspPaddr, 0);
        else begin
          logic [31:0] ep; int es; bit ef;
          ep = expPaddr.pop_front(); es = expSize.pop_front(); ef = expFault.pop_front();
          chk(rspPaddr == ep, "R3/R4/R6/R7/R8 paddr", rspPaddr, ep);
          chk(int'(rspSize) == es, "R3/R4/R6/R7/R8 size", 32'(rspSize), 32'(es));
          chk(rspFault == ef, "R8 fault flag", 32'(rspFault), 32'(ef));
          if (ef) mStat[1] = 1'b1;
        end
      end
      chk(irqOut == |(mStat & mEn), "R10 irq", 32'(irqOut), 32'(|(mStat & mEn)));
      chk(reqReady == (mRun && !busy), "R1 ready", 32'(reqReady), 32'(mRun && !busy));
    end
  end

  task automatic cfgWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(posedge clk);
    case (a)
      3'd0: mRun = d[0];
      3'd1: mBase = d;
      3'd2: mStat = mStat & ~d[4:0];
      3'd3: mEn = d[4:0];
      default: ;
    endcase
    #1 cfgWe = 1'b0;
  endtask

  task automatic cfgRead(input logic [2:0] a, input logic [31:0] e, input string req);
    @(negedge clk); cfgAddr = a; #2;
    chk(cfgRdata == e, req, cfgRdata, e);
  endtask

  task automatic doReq(input logic [31:0] va);
    @(negedge clk); reqValid = 1'b1; reqVaddr = va; #2;
    while (!reqReady) begin @(negedge clk); #2; end
    predict(va);
    @(posedge clk); busy = 1; #1 reqValid = 1'b0;
    while (expPaddr.size() != 0) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // table at 0x00010000, coarse table at 0x00020400
    memArr[32'h0001_0004] = 32'h8AB0_0002;   // va 0x001xxxxx section
    memArr[32'h0001_00D0] = 32'h7704_0002;   // va 0x034xxxxx supersection
    memArr[32'h0001_0158] = 32'h0002_0401;   // va 0x056xxxxx coarse
    memArr[32'h0001_0200] = 32'hFFFF_FFFF;   // va 0x080xxxxx low bits 11
    memArr[32'h0002_05E0] = 32'h1234_5002;   // 4 KB
    memArr[32'h0002_05E8] = 32'h5555_0003;   // both bits set
    memArr[32'h0002_0410] = 32'h9876_0001;   // 64 KB
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #2;
    chk(!rspValid && !irqOut && !reqReady && !memReqValid, "R1 reset state",
        {rspValid, irqOut, reqReady, memReqValid}, 0);
    cfgRead(3'd2, 0, "R9 reset status");
    cfgRead(3'd0, 0, "R1 reset run bit");
    cfgWrite(3'd1, 32'h0001_0000);
    // R1: request against a stopped walker is held off
    @(negedge clk); reqValid = 1'b1; reqVaddr = 32'h0012_3456;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #2;
      chk(!reqReady && !memReqValid, "R1 stopped hold-off", {reqReady, memReqValid}, 0);
    end
    cfgWrite(3'd0, 1);
    doReq(32'h0012_3456);        // R3
    doReq(32'h0345_6789);        // R4
    doReq(32'h0567_89AB);        // R5 R6
    doReq(32'h0567_A123);        // R6 priority
    doReq(32'h0560_4321);        // R7
    doReq(32'h0700_0000);        // R8 l1 00
    cfgRead(3'd2, 32'h2, "R9 status set");
    cfgRead(3'd4, 32'h0700_0000, "R9 fault address");
    cfgWrite(3'd3, 32'h2);       // R10 unmask
    @(negedge clk);
    cfgWrite(3'd2, 32'h1D);      // R9 writing 0 keeps bit 1
    cfgRead(3'd2, 32'h2, "R9 write-0 keeps bit");
    cfgWrite(3'd2, 32'h02);
    cfgRead(3'd2, 32'h0, "R9 write-1 clears");
    doReq(32'h0800_0000);        // R8 l1 11
    cfgRead(3'd4, 32'h0800_0000, "R9 fault address 2");
    cfgWrite(3'd2, 32'h02);
    doReq(32'h0560_0000);        // R8 l2 00
    cfgRead(3'd4, 32'h0560_0000, "R9 fault address 3");
    cfgWrite(3'd3, 32'h0);       // R10 masked
    doReq(32'h0012_0000);
    cfgWrite(3'd0, 0);
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule